// File: doc/BRIEF.md
# Security-Aware Exception Vector Router

This block decides where each incoming exception is taken on a core that runs both a secure and a non-secure world. In the cycle a request arrives, it picks one request by fixed priority. It applies the interrupt masks carried in the current status word and chooses a target mode. It then forms the vector address from one of three base registers: monitor, secure and non-secure. One cycle later it presents the result, together with strobes that tell the core to save the status word and capture the return address.

The block holds the world bit (0 = secure, 1 = non-secure) and the three vector base registers. The world bit changes only when software writes it while the status word shows monitor mode. The monitor base can be written only from the secure world. A write to the local vector base lands in the bank of the world that is current at that moment. Three routing bits redirect IRQ, FIQ and external abort to the monitor table. When a routing bit is clear, that exception is served by the current world's own table.

Top module: `exc_vector_router`

## Requirements
- R1: After reset the world bit `ns_o` is 0 (secure), `taken_o` is low, and all three vector bases are 0x00000000.
- R2: A monitor call (request bit 0) always enters monitor mode (mode code 5'b10110) at monitor base + 0x08, from either world.
- R3: Routing bits `route_i` bit 0 (IRQ), bit 1 (FIQ) and bit 2 (external abort) each send their exception to monitor mode at the monitor base, when the bit is set. The offsets are 0x18 for IRQ, 0x1C for FIQ and 0x10 for external abort.
- R4: A locally taken exception uses the secure base when `ns_o`=0 and the non-secure base when `ns_o`=1. The targets are: IRQ (bit 1) to mode 5'b10010 at offset 0x18; FIQ (bit 2) to 5'b10001 at 0x1C; external abort (bit 3) and data abort (bit 7) to 5'b10111 at 0x10; prefetch abort (bit 6) to 5'b10111 at 0x0C; supervisor call (bit 4) to 5'b10011 at 0x08; undefined (bit 5) to 5'b11011 at 0x04.
- R5: Among requests in the same cycle, the order is: data abort, then external abort, then FIQ, then IRQ, then prefetch abort, then monitor call, then supervisor call, then undefined.
- R6: One cycle after the request cycle, `taken_o`, `spsr_we_o` and `lr_we_o` are high, and `spsr_o` equals the `stat_i` of the request cycle.
- R7: `stat_o` is the request-cycle status word with bits [4:0] replaced by the target mode and bit 7 (IRQ mask) set. Bit 6 (FIQ mask) is also set when the target is FIQ or monitor mode. All other bits are copied unchanged.
- R8: An IRQ request is ignored while `stat_i` bit 7 is 1, and an FIQ request is ignored while `stat_i` bit 6 is 1. A lower-priority request is taken instead, if one is present.
- R9: A write to the world bit takes effect only when `stat_i[4:0]` is 5'b10110 (monitor mode) in the write cycle.
- R10: A write to the monitor base takes effect only while `ns_o` is 0. A local base write updates the secure base when `ns_o`=0 and the non-secure base when `ns_o`=1.
- R11: `taken_o` is high for exactly one cycle per request cycle that yields a taken exception, and low after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stat_i | input | STAT_W | Current status word: mode in [4:0], FIQ mask bit 6, IRQ mask bit 7 |
| req_i | input | 8 | Exception requests, one bit per source (see R4) |
| route_i | input | 3 | Monitor routing bits for IRQ, FIQ, external abort |
| ns_wr_i | input | 1 | World bit write strobe |
| ns_wdata_i | input | 1 | World bit write value |
| mbase_wr_i | input | 1 | Monitor base write strobe |
| vbase_wr_i | input | 1 | Local base write strobe (current world's bank) |
| base_wdata_i | input | ADDR_W | Base write value |
| ns_o | output | 1 | World bit, 1 = non-secure |
| taken_o | output | 1 | One-cycle pulse per taken exception |
| mode_o | output | 5 | Target mode |
| vec_o | output | ADDR_W | Vector address |
| spsr_o | output | STAT_W | Saved status word |
| spsr_we_o | output | 1 | Saved-status capture strobe |
| lr_we_o | output | 1 | Return-address capture strobe |
| stat_o | output | STAT_W | New status word on entry |

## Verification
The bench builds the block with its default values: 32-bit addresses and a 32-bit status word. With these widths, distinct non-zero bases in all three banks make every vector value unambiguous, so a wrong base choice or a wrong offset shows up directly on `vec_o`. The status words carry mask bits at bits 6 and 7 together with other set high bits. This brings within reach the masking fall-through of R8 and the bit preservation of R7. Walking the world bit through monitor and non-monitor writes covers both the gating of R9 and R10 and the banked base selection of R4.

// File: rtl/exr_pkg.sv
package exr_pkg;
    localparam int NREQ   = 8;
    localparam int MODE_W = 5;

    localparam int RQ_SMC  = 0;
    localparam int RQ_IRQ  = 1;
    localparam int RQ_FIQ  = 2;
    localparam int RQ_EABT = 3;
    localparam int RQ_SVC  = 4;
    localparam int RQ_UND  = 5;
    localparam int RQ_PABT = 6;
    localparam int RQ_DABT = 7;

    localparam int RT_IRQ  = 0;
    localparam int RT_FIQ  = 1;
    localparam int RT_EABT = 2;

    localparam int I_BIT = 7;
    localparam int F_BIT = 6;

    localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] M_MON = 5'b10110;
    localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] M_UND = 5'b11011;

    localparam logic [7:0] OFS_UND  = 8'h04;
    localparam logic [7:0] OFS_CALL = 8'h08;
    localparam logic [7:0] OFS_PABT = 8'h0C;
    localparam logic [7:0] OFS_DABT = 8'h10;
    localparam logic [7:0] OFS_IRQ  = 8'h18;
    localparam logic [7:0] OFS_FIQ  = 8'h1C;

    typedef enum logic [3:0] {
        SRC_NONE, SRC_DABT, SRC_EABT, SRC_FIQ, SRC_IRQ,
        SRC_PABT, SRC_SMC, SRC_SVC, SRC_UND
    } exr_src_e;
endpackage

// File: rtl/exr_arbiter.sv
module exr_arbiter
    import exr_pkg::*;
(
    input  logic [NREQ-1:0] req_i,
    input  logic            irq_mask_i,
    input  logic            fiq_mask_i,
    output exr_src_e        src_o
);
    always_comb begin
        src_o = SRC_NONE;
        if (req_i[RQ_DABT])                     src_o = SRC_DABT;
        else if (req_i[RQ_EABT])                src_o = SRC_EABT;
        else if (req_i[RQ_FIQ] && !fiq_mask_i)  src_o = SRC_FIQ;
        else if (req_i[RQ_IRQ] && !irq_mask_i)  src_o = SRC_IRQ;
        else if (req_i[RQ_PABT])                src_o = SRC_PABT;
        else if (req_i[RQ_SMC])                 src_o = SRC_SMC;
        else if (req_i[RQ_SVC])                 src_o = SRC_SVC;
        else if (req_i[RQ_UND])                 src_o = SRC_UND;
    end
endmodule

// File: rtl/exr_route.sv
module exr_route
    import exr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  exr_src_e            src_i,
    input  logic [2:0]          route_i,
    input  logic                ns_i,
    input  logic [ADDR_W-1:0]   mbase_i,
    input  logic [ADDR_W-1:0]   sbase_i,
    input  logic [ADDR_W-1:0]   nbase_i,
    output logic                valid_o,
    output logic [MODE_W-1:0]   mode_o,
    output logic [ADDR_W-1:0]   vec_o
);
    logic [ADDR_W-1:0] local_base;
    logic [ADDR_W-1:0] base;
    logic [7:0]        ofs;
    logic              to_mon;

    assign local_base = ns_i ? nbase_i : sbase_i;

    always_comb begin
        valid_o = 1'b1;
        to_mon  = 1'b0;
        mode_o  = M_SVC;
        ofs     = OFS_CALL;
        unique case (src_i)
            SRC_SMC:  begin to_mon = 1'b1;               ofs = OFS_CALL; end
            SRC_IRQ:  begin to_mon = route_i[RT_IRQ];  mode_o = M_IRQ; ofs = OFS_IRQ; end
            SRC_FIQ:  begin to_mon = route_i[RT_FIQ];  mode_o = M_FIQ; ofs = OFS_FIQ; end
            SRC_EABT: begin to_mon = route_i[RT_EABT]; mode_o = M_ABT; ofs = OFS_DABT; end
            SRC_DABT: begin mode_o = M_ABT; ofs = OFS_DABT; end
            SRC_PABT: begin mode_o = M_ABT; ofs = OFS_PABT; end
            SRC_SVC:  begin mode_o = M_SVC; ofs = OFS_CALL; end
            SRC_UND:  begin mode_o = M_UND; ofs = OFS_UND;  end
            default:  valid_o = 1'b0;
        endcase
        if (to_mon) mode_o = M_MON;
        base  = to_mon ? mbase_i : local_base;
        vec_o = base + ADDR_W'(ofs);
    end
endmodule

// File: rtl/exc_vector_router.sv
module exc_vector_router
    import exr_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                STAT_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_BASE = '0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [STAT_W-1:0]  stat_i,
    input  logic [NREQ-1:0]    req_i,
    input  logic [2:0]         route_i,
    input  logic               ns_wr_i,
    input  logic               ns_wdata_i,
    input  logic               mbase_wr_i,
    input  logic               vbase_wr_i,
    input  logic [ADDR_W-1:0]  base_wdata_i,
    output logic               ns_o,
    output logic               taken_o,
    output logic [MODE_W-1:0]  mode_o,
    output logic [ADDR_W-1:0]  vec_o,
    output logic [STAT_W-1:0]  spsr_o,
    output logic               spsr_we_o,
    output logic               lr_we_o,
    output logic [STAT_W-1:0]  stat_o
);
    typedef struct packed {
        logic              ns;
        logic [ADDR_W-1:0] mbase;
        logic [ADDR_W-1:0] sbase;
        logic [ADDR_W-1:0] nbase;
        logic              valid;
        logic [MODE_W-1:0] mode;
        logic [ADDR_W-1:0] vec;
        logic [STAT_W-1:0] spsr;
        logic [STAT_W-1:0] nstat;
    } state_t;

    state_t            st_d, st_q;
    exr_src_e          src;
    logic              hit;
    logic [MODE_W-1:0] tgt_mode;
    logic [ADDR_W-1:0] tgt_vec;

    exr_arbiter u_arb (
        .req_i      (req_i),
        .irq_mask_i (stat_i[I_BIT]),
        .fiq_mask_i (stat_i[F_BIT]),
        .src_o      (src)
    );

    exr_route #(.ADDR_W(ADDR_W)) u_route (
        .src_i   (src),
        .route_i (route_i),
        .ns_i    (st_q.ns),
        .mbase_i (st_q.mbase),
        .sbase_i (st_q.sbase),
        .nbase_i (st_q.nbase),
        .valid_o (hit),
        .mode_o  (tgt_mode),
        .vec_o   (tgt_vec)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = hit;
        if (hit) begin
            st_d.mode         = tgt_mode;
            st_d.vec          = tgt_vec;
            st_d.spsr         = stat_i;
            st_d.nstat        = stat_i;
            st_d.nstat[4:0]   = tgt_mode;
            st_d.nstat[I_BIT] = 1'b1;
            if (tgt_mode == M_FIQ || tgt_mode == M_MON)
                st_d.nstat[F_BIT] = 1'b1;
        end
        if (ns_wr_i && stat_i[4:0] == M_MON)
            st_d.ns = ns_wdata_i;
        if (mbase_wr_i && !st_q.ns)
            st_d.mbase = base_wdata_i;
        if (vbase_wr_i) begin
            if (st_q.ns) st_d.nbase = base_wdata_i;
            else         st_d.sbase = base_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.mbase <= RESET_BASE;
            st_q.sbase <= RESET_BASE;
            st_q.nbase <= RESET_BASE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ns_o      = st_q.ns;
    assign taken_o   = st_q.valid;
    assign mode_o    = st_q.mode;
    assign vec_o     = st_q.vec;
    assign spsr_o    = st_q.spsr;
    assign spsr_we_o = st_q.valid;
    assign lr_we_o   = st_q.valid;
    assign stat_o    = st_q.nstat;
endmodule

// File: rtl/exr_checker.sv
module exr_checker
    import exr_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [STAT_W-1:0] stat_i,
    input logic [NREQ-1:0]   req_i,
    input logic              ns_o,
    input logic              taken_o,
    input logic [MODE_W-1:0] mode_o,
    input logic [STAT_W-1:0] spsr_o,
    input logic [STAT_W-1:0] stat_o
);
    AST_RESET_SECURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rst_ni) |-> !ns_o); // R1

    AST_WORLD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ns_o != $past(ns_o)) |-> ($past(stat_i[4:0]) == M_MON)); // R9

    AST_SPSR_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        taken_o |-> (spsr_o == $past(stat_i))); // R6

    AST_IRQ_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        taken_o |-> stat_o[I_BIT]); // R7

    AST_FIQ_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (taken_o && (mode_o == M_FIQ || mode_o == M_MON)) |-> stat_o[F_BIT]); // R7

    AST_IRQ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(req_i == NREQ'(1 << RQ_IRQ) && stat_i[I_BIT]) |-> !taken_o); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(req_i) == '0) |-> !taken_o); // R11
endmodule

bind exc_vector_router exr_checker #(.STAT_W(STAT_W)) u_exr_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stat_i  (stat_i),
    .req_i   (req_i),
    .ns_o    (ns_o),
    .taken_o (taken_o),
    .mode_o  (mode_o),
    .spsr_o  (spsr_o),
    .stat_o  (stat_o)
);

// File: tb/tb_exc_vector_router.sv
`timescale 1ns/1ps
module tb_exc_vector_router;
    localparam int AW = 32;
    localparam int SW = 32;
    localparam logic [4:0] MFIQ = 5'b10001, MIRQ = 5'b10010, MSVC = 5'b10011,
                           MMON = 5'b10110, MABT = 5'b10111, MUND = 5'b11011;
    localparam logic [31:0] ST_SVC = 32'h6000_0013;
    localparam logic [31:0] ST_MON = 32'h6000_0016;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [SW-1:0] stat_i = ST_SVC;
    logic [7:0]    req_i = '0;
    logic [2:0]    route_i = '0;
    logic ns_wr_i = 0, ns_wdata_i = 0, mbase_wr_i = 0, vbase_wr_i = 0;
    logic [AW-1:0] base_wdata_i = '0;
    logic          ns_o, taken_o, spsr_we_o, lr_we_o;
    logic [4:0]    mode_o;
    logic [AW-1:0] vec_o;
    logic [SW-1:0] spsr_o, stat_o;

    always #2.5 clk = ~clk;

    exc_vector_router #(.ADDR_W(AW), .STAT_W(SW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .stat_i(stat_i), .req_i(req_i), .route_i(route_i),
        .ns_wr_i(ns_wr_i), .ns_wdata_i(ns_wdata_i), .mbase_wr_i(mbase_wr_i),
        .vbase_wr_i(vbase_wr_i), .base_wdata_i(base_wdata_i), .ns_o(ns_o),
        .taken_o(taken_o), .mode_o(mode_o), .vec_o(vec_o), .spsr_o(spsr_o),
        .spsr_we_o(spsr_we_o), .lr_we_o(lr_we_o), .stat_o(stat_o)
    );

    typedef struct {
        logic        valid;
        logic [4:0]  mode;
        logic [31:0] vec;
        logic [31:0] spsr;
        logic [31:0] nstat;
        string       tag;
    } exp_t;

    exp_t q[$];
    int tests = 0, fails = 0;
    logic m_ns = 0;
    logic [31:0] m_mb = 0, m_sb = 0, m_nb = 0;

    function automatic exp_t model(input logic [7:0] rq, input logic [31:0] st, input string tag);
        exp_t e;
        logic mon;
        logic [7:0] ofs;
        e.valid = 1; e.tag = tag; mon = 0; e.mode = MSVC; ofs = 8'h08;
        if (rq[7])                 begin e.mode = MABT; ofs = 8'h10; end
        else if (rq[3])            begin e.mode = MABT; ofs = 8'h10; mon = route_i[2]; end
        else if (rq[2] && !st[6])  begin e.mode = MFIQ; ofs = 8'h1C; mon = route_i[1]; end
        else if (rq[1] && !st[7])  begin e.mode = MIRQ; ofs = 8'h18; mon = route_i[0]; end
        else if (rq[6])            begin e.mode = MABT; ofs = 8'h0C; end
        else if (rq[0])            begin mon = 1; ofs = 8'h08; end
        else if (rq[4])            begin e.mode = MSVC; ofs = 8'h08; end
        else if (rq[5])            begin e.mode = MUND; ofs = 8'h04; end
        else e.valid = 0;
        if (mon) e.mode = MMON;
        e.vec = (mon ? m_mb : (m_ns ? m_nb : m_sb)) + {24'h0, ofs};
        e.spsr = st;
        e.nstat = st;
        e.nstat[4:0] = e.mode;
        e.nstat[7] = 1'b1;
        if (e.mode == MFIQ || e.mode == MMON) e.nstat[6] = 1'b1;
        return e;
    endfunction

    task automatic fire(input logic [7:0] rq, input logic [31:0] st, input string tag);
        @(negedge clk);
        req_i = rq; stat_i = st;
        q.push_back(model(rq, st, tag));
        @(posedge clk); #1;
        req_i = '0;
    endtask

    // kind: 0 world bit, 1 monitor base, 2 local base
    task automatic wr(input int kind, input logic [31:0] data, input logic [31:0] st);
        @(negedge clk);
        stat_i = st; base_wdata_i = data; ns_wdata_i = data[0];
        if (kind == 0) begin ns_wr_i = 1; if (st[4:0] == MMON) m_ns = data[0]; end
        if (kind == 1) begin mbase_wr_i = 1; if (!m_ns) m_mb = data; end
        if (kind == 2) begin vbase_wr_i = 1; if (m_ns) m_nb = data; else m_sb = data; end
        @(posedge clk); #1;
        ns_wr_i = 0; mbase_wr_i = 0; vbase_wr_i = 0;
    endtask

    task automatic chk_ns(input string tag);
        @(negedge clk);
        tests++;
        if (ns_o !== m_ns) begin
            fails++;
            $display("FAIL %s: ns_o actual %0b expected %0b", tag, ns_o, m_ns);
        end
    endtask

    always @(posedge clk) begin
        exp_t e;
        #2;
        if (q.size() > 0) begin
            e = q.pop_front();
            tests++;
            if (taken_o !== e.valid ||
                (e.valid && (mode_o !== e.mode || vec_o !== e.vec || spsr_o !== e.spsr ||
                             stat_o !== e.nstat || !spsr_we_o || !lr_we_o))) begin
                fails++;
                $display("FAIL %s: actual v=%0b m=%b vec=%h spsr=%h st=%h we=%0b%0b expected v=%0b m=%b vec=%h spsr=%h st=%h",
                         e.tag, taken_o, mode_o, vec_o, spsr_o, stat_o, spsr_we_o, lr_we_o,
                         e.valid, e.mode, e.vec, e.spsr, e.nstat);
            end
        end
    end

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++;
        if (ns_o !== 1'b0 || taken_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 in reset: actual ns=%0b taken=%0b expected 0 0", ns_o, taken_o);
        end
        rst_n = 1'b1;
        chk_ns("R1 after reset");
        fire(8'h01, ST_SVC, "R1 R2 reset bases smc");
        fire(8'h02, ST_SVC, "R1 R4 reset bases irq");

        wr(2, 32'h0000_1000, ST_MON);
        wr(1, 32'h0000_3000, ST_MON);
        wr(0, 32'h1, ST_MON);
        chk_ns("R9 world write in monitor");
        wr(2, 32'h0000_2000, ST_MON);
        wr(1, 32'h0000_4000, ST_MON);
        wr(0, 32'h0, ST_SVC);
        chk_ns("R9 world write outside monitor ignored");

        route_i = 3'b000;
        fire(8'h02, ST_SVC, "R4 irq local ns");
        fire(8'h04, ST_SVC, "R4 fiq local ns");
        fire(8'h08, ST_SVC, "R4 eabt local ns");
        fire(8'h80, ST_SVC, "R4 dabt local ns");
        fire(8'h40, ST_SVC, "R4 pabt local ns");
        fire(8'h10, ST_SVC, "R4 svc local ns");
        fire(8'h20, ST_SVC, "R4 und local ns");
        fire(8'h01, ST_SVC, "R2 R10 smc from ns, mbase write ignored");

        route_i = 3'b111;
        fire(8'h02, ST_SVC, "R3 irq routed");
        fire(8'h04, ST_SVC, "R3 fiq routed");
        fire(8'h08, ST_SVC, "R3 eabt routed");
        fire(8'h80, ST_SVC, "R3 dabt never routed");
        route_i = 3'b010;
        fire(8'h02, ST_SVC, "R3 irq bit clear stays local");

        route_i = 3'b000;
        fire(8'hFF, ST_SVC, "R5 all -> dabt");
        fire(8'h7F, ST_SVC, "R5 eabt over fiq");
        fire(8'h77, ST_SVC, "R5 fiq over irq");
        fire(8'h73, ST_SVC, "R5 irq over pabt");
        fire(8'h71, ST_SVC, "R5 pabt over smc");
        fire(8'h31, ST_SVC, "R5 smc over svc");
        fire(8'h30, ST_SVC, "R5 svc over und");

        fire(8'h02, ST_SVC | 32'h80, "R8 irq masked");
        fire(8'h04, ST_SVC | 32'h40, "R8 fiq masked");
        fire(8'h06, ST_SVC | 32'h40, "R8 fiq masked falls to irq");
        fire(8'h22, ST_SVC | 32'h80, "R8 irq masked falls to und");
        fire(8'h02, 32'hA5A5_A613, "R6 R7 bits preserved");

        fire(8'h02, ST_SVC, "R11 taken");
        fire(8'h00, ST_SVC, "R11 idle after pulse");
        fire(8'h00, ST_SVC, "R11 idle");

        wr(0, 32'h0, ST_MON);
        chk_ns("R9 back to secure");
        fire(8'h02, ST_SVC, "R4 irq local secure base");
        wr(1, 32'h0000_5000, ST_MON);
        fire(8'h01, ST_SVC, "R10 mbase write in secure");
        wr(2, 32'h0000_6000, ST_SVC);
        fire(8'h20, ST_SVC, "R10 local write to secure bank");

        repeat (3) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule